// File: doc/BRIEF.md
# Two-Level Interrupt Source Dispatcher

This block holds the pending state of up to 256 interrupt channels, each with eight sources, and turns it into a serial stream of interrupt events. A channel counts as active when its enable bit is set and at least one of its sources is pending. Active channels are gathered into 32-bit summary words. Whenever any channel is active and no walk is in progress, the block starts a walk over the summary words. For every active channel it finds, it takes a snapshot of the eight source bits. It then emits one event for each set bit.

Each channel also stores a peripheral identifier, written when the channel is registered. Registration widens a channel window, and the walk only visits the summary words that this window touches. Software-style operations are single-cycle pulses: raise sources, acknowledge one source, mask or unmask a channel, and register a channel.

Events leave on a valid/ready stream. An event is offered with `ev_valid` and is consumed on a clock edge where `ev_ready` is high. While `ev_ready` is low, the offered event is held unchanged and the walk does not advance.

Top module: `irq_dispatch`

## Requirements
- R1: After reset no event is offered, `irq_out` is low, every channel is masked, and the channel window is empty (low bound 255, high bound 0), so no walk takes place.
- R2: `irq_out` is high exactly when some channel has its enable bit set and a non-zero source status. It follows a raise, acknowledge or enable change one clock edge later.
- R3: A walk visits summary words `lo>>5` through `hi>>5` of the channel window, in ascending order. An active channel outside those words yields no event, though `irq_out` stays high. Registering a channel lowers `lo` or raises `hi` to include it.
- R4: Within a summary word, channels are served from the lowest set bit upward. Each served bit is removed from a working copy of the word until that copy is zero.
- R5: Within a channel, sources are emitted from index 0 upward, taken from a snapshot of the channel's status made when the channel is selected.
- R6: `ev_id` is formed as follows: bits 7:0 hold the channel, bits 10:8 hold the source index, bits 15:11 are zero, and the bits from 16 up hold the peripheral identifier. The identifier is captured when the channel is selected.
- R7: An acknowledge clears only source `ack_src` of channel `ack_chan`. A raise to the same channel in the same cycle takes priority for the bits it sets. Acknowledging a clear bit, or a source of another channel, leaves the status unchanged.
- R8: `en_set`=0 clears a channel's enable and `en_set`=1 sets it. Repeating either operation changes nothing. A masked channel with pending sources neither drives `irq_out` nor yields events.
- R9: While `ev_valid` is high and `ev_ready` is low, `ev_valid` stays high and `ev_id` stays stable on the next cycle.
- R10: A new walk begins only after the previous one has ended and while `irq_out` is high. A source left unacknowledged is delivered again, once per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| raise_valid | input | 1 | Pulse: OR `raise_bits` into a channel's status |
| raise_chan | input | 8 | Channel targeted by a raise |
| raise_bits | input | 8 | Source bits to set |
| ack_valid | input | 1 | Pulse: acknowledge one source |
| ack_chan | input | 8 | Channel being acknowledged |
| ack_src | input | 3 | Source index being acknowledged |
| en_valid | input | 1 | Pulse: mask or unmask a channel |
| en_chan | input | 8 | Channel being masked or unmasked |
| en_set | input | 1 | 1 = unmask, 0 = mask |
| reg_valid | input | 1 | Pulse: register a channel |
| reg_chan | input | 8 | Channel being registered |
| reg_pid | input | PID_W | Peripheral identifier stored for the channel |
| irq_out | output | 1 | Aggregate interrupt: some enabled channel is pending |
| ev_valid | output | 1 | Event offered |
| ev_ready | input | 1 | Consumer accepts the offered event |
| ev_id | output | PID_W+16 | Event: identifier, source and channel |

## Verification
A corrupted working copy or status snapshot shows up at the ports as events in the wrong order, duplicated events or missing events. The scoreboard catches any of these at the first handshake that disagrees with its queue. A wrong window bound shows up either as silence while `irq_out` stays high, or as an event from a channel outside the window, which is flagged in the cycle it is offered. A stale enable or status bit is visible on `irq_out` one edge after the pulse that should have changed it. A lost acknowledge appears as an extra delivery in the next walk, a few cycles later.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int CH_W    = 8;   // channel field width inside an event
  localparam int SRC_N   = 8;   // sources per channel
  localparam int SRC_IW  = 3;
  localparam int WORD_N  = 32;  // channels per summary word
  localparam int WORD_IW = 5;
  localparam int WSEL_W  = CH_W - WORD_IW;
  localparam int SPAN    = 1 << CH_W;

  typedef enum logic [1:0] {
    SC_IDLE,
    SC_WORD,
    SC_EMIT
  } scan_st_t;
endpackage

// File: rtl/irqd_lsb.sv
module irqd_lsb #(
  parameter int N  = 32,
  parameter int IW = 5
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign any = |vec;
endmodule

// File: rtl/irqd_store.sv
module irqd_store
  import irqd_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int PID_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    raise_valid,
  input  logic [CH_W-1:0]         raise_chan,
  input  logic [SRC_N-1:0]        raise_bits,
  input  logic                    ack_valid,
  input  logic [CH_W-1:0]         ack_chan,
  input  logic [SRC_IW-1:0]       ack_src,
  input  logic                    en_valid,
  input  logic [CH_W-1:0]         en_chan,
  input  logic                    en_set,
  input  logic                    reg_valid,
  input  logic [CH_W-1:0]         reg_chan,
  input  logic [PID_W-1:0]        reg_pid,
  output logic [NUM_CH*SRC_N-1:0] stat_flat,
  output logic [NUM_CH-1:0]       en_flat,
  output logic [NUM_CH*PID_W-1:0] pid_flat,
  output logic [CH_W-1:0]         lo_ch,
  output logic [CH_W-1:0]         hi_ch
);
  logic reg_ok;
  assign reg_ok = reg_valid && ({1'b0, reg_chan} < (CH_W+1)'(NUM_CH));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [CH_W-1:0] CID = CH_W'(c);
    logic [SRC_N-1:0] clr_m, set_m, stat_q;
    logic [PID_W-1:0] pid_q;
    logic             en_q;

    assign clr_m = (ack_valid && ack_chan == CID) ? (SRC_N'(1) << ack_src) : '0;
    assign set_m = (raise_valid && raise_chan == CID) ? raise_bits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stat_q <= '0;
        en_q   <= 1'b0;
        pid_q  <= '0;
      end else begin
        stat_q <= (stat_q & ~clr_m) | set_m;
        if (en_valid && en_chan == CID) begin
          if (en_set && !en_q) en_q <= 1'b1;
          else if (!en_set && en_q) en_q <= 1'b0;
        end
        if (reg_valid && reg_chan == CID) pid_q <= reg_pid;
      end
    end

    assign stat_flat[c*SRC_N +: SRC_N] = stat_q;
    assign pid_flat[c*PID_W +: PID_W]  = pid_q;
    assign en_flat[c]                  = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_ch <= '1;
      hi_ch <= '0;
    end else if (reg_ok) begin
      if (reg_chan < lo_ch) lo_ch <= reg_chan;
      if (reg_chan > hi_ch) hi_ch <= reg_chan;
    end
  end
endmodule

// File: rtl/irqd_scan.sv
module irqd_scan
  import irqd_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int PID_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    irq,
  input  logic [NUM_CH-1:0]       sum,
  input  logic [NUM_CH*SRC_N-1:0] stat_flat,
  input  logic [NUM_CH*PID_W-1:0] pid_flat,
  input  logic [CH_W-1:0]         lo_ch,
  input  logic [CH_W-1:0]         hi_ch,
  output logic                    ev_valid,
  input  logic                    ev_ready,
  output logic [PID_W+15:0]       ev_id
);
  localparam int SRC_PAD = 8 - SRC_IW;

  logic [SPAN-1:0]       sum_ext;
  logic [SPAN*SRC_N-1:0] stat_ext;
  logic [SPAN*PID_W-1:0] pid_ext;

  assign sum_ext  = SPAN'(sum);
  assign stat_ext = (SPAN*SRC_N)'(stat_flat);
  assign pid_ext  = (SPAN*PID_W)'(pid_flat);

  scan_st_t          st;
  logic [WSEL_W-1:0] wi, first_w, last_w, wsel;
  logic [WORD_N-1:0] wcopy, word_rd;
  logic [CH_W-1:0]   ch, ch_n;
  logic [SRC_N-1:0]  scopy;
  logic [PID_W-1:0]  pid_q;
  logic [WORD_IW-1:0] wbit;
  logic [SRC_IW-1:0]  sbit;
  logic               wany, sany;

  irqd_lsb #(.N(WORD_N), .IW(WORD_IW)) u_wpick (.vec(wcopy), .idx(wbit), .any(wany));
  irqd_lsb #(.N(SRC_N),  .IW(SRC_IW))  u_spick (.vec(scopy), .idx(sbit), .any(sany));

  assign first_w = lo_ch[CH_W-1 -: WSEL_W];
  assign last_w  = hi_ch[CH_W-1 -: WSEL_W];
  assign wsel    = (st == SC_IDLE) ? first_w : wi + 1'b1;
  assign word_rd = sum_ext[{wsel, {WORD_IW{1'b0}}} +: WORD_N];
  assign ch_n    = {wi, wbit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SC_IDLE;
      wi    <= '0;
      wcopy <= '0;
      ch    <= '0;
      scopy <= '0;
      pid_q <= '0;
    end else begin
      case (st)
        SC_IDLE: begin
          if (irq && lo_ch <= hi_ch) begin
            wi    <= first_w;
            wcopy <= word_rd;
            st    <= SC_WORD;
          end
        end
        SC_WORD: begin
          if (!wany) begin
            if (wi >= last_w) st <= SC_IDLE;
            else begin
              wi    <= wsel;
              wcopy <= word_rd;
            end
          end else begin
            ch    <= ch_n;
            scopy <= stat_ext[{ch_n, {SRC_IW{1'b0}}} +: SRC_N];
            pid_q <= pid_ext[int'(ch_n)*PID_W +: PID_W];
            st    <= SC_EMIT;
          end
        end
        SC_EMIT: begin
          if (!sany) begin
            wcopy[ch[WORD_IW-1:0]] <= 1'b0;
            st <= SC_WORD;
          end else if (ev_ready) begin
            scopy[sbit] <= 1'b0;
          end
        end
        default: st <= SC_IDLE;
      endcase
    end
  end

  assign ev_valid = (st == SC_EMIT) && sany;
  assign ev_id    = {pid_q, {SRC_PAD{1'b0}}, sbit, ch};
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irqd_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int PID_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               raise_valid,
  input  logic [7:0]         raise_chan,
  input  logic [7:0]         raise_bits,
  input  logic               ack_valid,
  input  logic [7:0]         ack_chan,
  input  logic [2:0]         ack_src,
  input  logic               en_valid,
  input  logic [7:0]         en_chan,
  input  logic               en_set,
  input  logic               reg_valid,
  input  logic [7:0]         reg_chan,
  input  logic [PID_W-1:0]   reg_pid,
  output logic               irq_out,
  output logic               ev_valid,
  input  logic               ev_ready,
  output logic [PID_W+15:0]  ev_id
);
  logic [NUM_CH*SRC_N-1:0] stat_flat;
  logic [NUM_CH-1:0]       en_flat, sum;
  logic [NUM_CH*PID_W-1:0] pid_flat;
  logic [CH_W-1:0]         lo_ch, hi_ch;

  irqd_store #(.NUM_CH(NUM_CH), .PID_W(PID_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .raise_valid(raise_valid), .raise_chan(raise_chan), .raise_bits(raise_bits),
    .ack_valid(ack_valid), .ack_chan(ack_chan), .ack_src(ack_src),
    .en_valid(en_valid), .en_chan(en_chan), .en_set(en_set),
    .reg_valid(reg_valid), .reg_chan(reg_chan), .reg_pid(reg_pid),
    .stat_flat(stat_flat), .en_flat(en_flat), .pid_flat(pid_flat),
    .lo_ch(lo_ch), .hi_ch(hi_ch)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sum
    assign sum[c] = en_flat[c] & (|stat_flat[c*SRC_N +: SRC_N]);
  end

  assign irq_out = |sum;

  irqd_scan #(.NUM_CH(NUM_CH), .PID_W(PID_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .irq(irq_out), .sum(sum),
    .stat_flat(stat_flat), .pid_flat(pid_flat),
    .lo_ch(lo_ch), .hi_ch(hi_ch),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_id(ev_id)
  );
endmodule

// File: rtl/irqd_chk.sv
module irqd_chk #(
  parameter int NUM_CH = 64,
  parameter int PID_W  = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                raise_valid,
  input logic [7:0]          raise_chan,
  input logic [7:0]          raise_bits,
  input logic                ack_valid,
  input logic [7:0]          ack_chan,
  input logic [2:0]          ack_src,
  input logic                en_valid,
  input logic [7:0]          en_chan,
  input logic                en_set,
  input logic                ev_valid,
  input logic                ev_ready,
  input logic [PID_W+15:0]   ev_id,
  input logic [NUM_CH*8-1:0] stat_flat,
  input logic [NUM_CH-1:0]   en_flat,
  input logic [7:0]          lo_ch,
  input logic [7:0]          hi_ch
);
  logic ack_in, en_in;
  assign ack_in = ack_valid && ({1'b0, ack_chan} < 9'(NUM_CH));
  assign en_in  = en_valid && ({1'b0, en_chan} < 9'(NUM_CH));

  assert_quiet_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !ev_valid);

  assert_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> (ev_id[7:5] >= lo_ch[7:5]) && (ev_id[7:5] <= hi_ch[7:5]));

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && !(raise_valid && raise_chan == ack_chan && raise_bits[ack_src]))
      |=> !stat_flat[{$past(ack_chan), $past(ack_src)}]);

  assert_enable_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en_in |=> en_flat[$past(en_chan)] == $past(en_set));

  assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> ev_valid && $stable(ev_id));
endmodule

bind irq_dispatch irqd_chk #(.NUM_CH(NUM_CH), .PID_W(PID_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .raise_valid(raise_valid), .raise_chan(raise_chan), .raise_bits(raise_bits),
  .ack_valid(ack_valid), .ack_chan(ack_chan), .ack_src(ack_src),
  .en_valid(en_valid), .en_chan(en_chan), .en_set(en_set),
  .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_id(ev_id),
  .stat_flat(stat_flat), .en_flat(en_flat), .lo_ch(lo_ch), .hi_ch(hi_ch)
);

// File: tb/sim_irq_dispatch.sv
`timescale 1ns/1ps
module sim_irq_dispatch;
  localparam int PID_W = 12;
  localparam int EV_W  = PID_W + 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic raise_valid = 1'b0;
  logic [7:0] raise_chan = '0, raise_bits = '0;
  logic ack_valid = 1'b0;
  logic [7:0] ack_chan = '0;
  logic [2:0] ack_src = '0;
  logic en_valid = 1'b0, en_set = 1'b0;
  logic [7:0] en_chan = '0;
  logic reg_valid = 1'b0;
  logic [7:0] reg_chan = '0;
  logic [PID_W-1:0] reg_pid = '0;
  logic ev_ready = 1'b0;
  logic irq_out, ev_valid;
  logic [EV_W-1:0] ev_id;

  always #2 clk = ~clk;

  irq_dispatch u0 (
    .clk(clk), .rst_n(rst_n),
    .raise_valid(raise_valid), .raise_chan(raise_chan), .raise_bits(raise_bits),
    .ack_valid(ack_valid), .ack_chan(ack_chan), .ack_src(ack_src),
    .en_valid(en_valid), .en_chan(en_chan), .en_set(en_set),
    .reg_valid(reg_valid), .reg_chan(reg_chan), .reg_pid(reg_pid),
    .irq_out(irq_out), .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_id(ev_id)
  );

  // scoreboard
  logic [EV_W-1:0] exp_q[$];
  string           tag_q[$];
  int ack_mode = 1;            // 0 none, 1 every event, 2 only when queue drains
  int man_cnt = 0, man_seen = 0;
  logic [7:0] man_chan = '0;
  logic [2:0] man_src = '0;
  int n_chk = 0, n_fail = 0, m_chk = 0, m_fail = 0;
  bit main_done = 0;

  function automatic logic [EV_W-1:0] mk(input logic [PID_W-1:0] pid, input int src, input int ch);
    return {pid, 5'b0, 3'(src), 8'(ch)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic mchk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    m_chk++;
    if (!ok) begin
      m_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: samples at the falling edge, owns the acknowledge pins
  logic stall_prev = 1'b0;
  logic [EV_W-1:0] prev_id = '0;
  always @(negedge clk) begin
    if (!rst_n) begin
      ack_valid = 1'b0;
      stall_prev = 1'b0;
      man_seen = man_cnt;
    end else begin
      if (stall_prev)
        mchk(ev_valid && ev_id == prev_id, "R9 held event", 32'(ev_id), 32'(prev_id));
      stall_prev = ev_valid && !ev_ready;
      prev_id = ev_id;
      ack_valid = 1'b0;
      if (ev_valid && ev_ready) begin
        if (exp_q.size() == 0) begin
          mchk(1'b0, "R3 R10 unexpected event", 32'(ev_id), 32'h0);
        end else begin
          logic [EV_W-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          mchk(ev_id == e, t, 32'(ev_id), 32'(e));
          if (ack_mode == 1 || (ack_mode == 2 && exp_q.size() == 0)) begin
            ack_valid = 1'b1;
            ack_chan = ev_id[7:0];
            ack_src = ev_id[10:8];
          end
        end
      end
      if (!ack_valid && man_cnt != man_seen) begin
        ack_valid = 1'b1;
        ack_chan = man_chan;
        ack_src = man_src;
        man_seen = man_cnt;
      end
    end
  end

  task automatic expect_ev(input logic [PID_W-1:0] pid, input int src, input int ch, input string t);
    exp_q.push_back(mk(pid, src, ch));
    tag_q.push_back(t);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ev_ready = 1'b0;
    ack_mode = 1;
    exp_q.delete();
    tag_q.delete();
    repeat (3) step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic raise(input int ch, input logic [7:0] bits);
    raise_valid = 1'b1; raise_chan = 8'(ch); raise_bits = bits;
    step();
    raise_valid = 1'b0;
  endtask

  task automatic set_en(input int ch, input bit on);
    en_valid = 1'b1; en_chan = 8'(ch); en_set = on;
    step();
    en_valid = 1'b0;
  endtask

  task automatic regc(input int ch, input logic [PID_W-1:0] pid);
    reg_valid = 1'b1; reg_chan = 8'(ch); reg_pid = pid;
    step();
    reg_valid = 1'b0;
  endtask

  task automatic man_ack(input int ch, input int src);
    man_chan = 8'(ch); man_src = 3'(src); man_cnt++;
    step(); step();
  endtask

  task automatic wait_empty(input string t);
    int n = 0;
    while (exp_q.size() != 0 && n < 3000) begin step(); n++; end
    chk(exp_q.size() == 0, t, 32'(exp_q.size()), 32'h0);
    repeat (30) step();
  endtask

  task automatic look_irq(input logic e, input string t);
    @(negedge clk);
    chk(irq_out == e, t, 32'(irq_out), 32'(e));
    step();
  endtask

  initial begin
    // R1: reset state
    do_reset();
    @(negedge clk);
    chk(ev_valid == 1'b0, "R1 no event after reset", 32'(ev_valid), 32'h0);
    chk(irq_out == 1'b0, "R1 irq low after reset", 32'(irq_out), 32'h0);
    ev_ready = 1'b1;
    raise(4, 8'h01);
    look_irq(1'b0, "R8 channel masked by reset");
    set_en(4, 1'b1);
    look_irq(1'b1, "R2 irq follows unmask");
    repeat (40) step();   // empty window: no events (monitor)
    chk(ev_valid == 1'b0, "R1 R3 empty window, no walk", 32'(ev_valid), 32'h0);
    set_en(4, 1'b0);
    look_irq(1'b0, "R2 irq follows mask");

    // R4 R5 R6 R9: ordering, format and stall
    do_reset();
    raise(9, 8'h12);
    raise(3, 8'hA4);
    raise(35, 8'h01);
    set_en(3, 1'b1); set_en(9, 1'b1); set_en(35, 1'b1);
    expect_ev(12'h1A5, 2, 3, "R5 R6 ch3 src2");
    expect_ev(12'h1A5, 5, 3, "R5 ch3 src5");
    expect_ev(12'h1A5, 7, 3, "R5 ch3 src7");
    expect_ev(12'h0C3, 1, 9, "R4 ch9 src1");
    expect_ev(12'h0C3, 4, 9, "R5 ch9 src4");
    expect_ev(12'hFFF, 0, 35, "R4 R6 ch35 second word");
    regc(3, 12'h1A5);
    regc(9, 12'h0C3);
    regc(35, 12'hFFF);
    repeat (8) step();
    @(negedge clk);
    chk(ev_valid == 1'b1, "R9 valid held while stalled", 32'(ev_valid), 32'h1);
    chk(ev_id == mk(12'h1A5, 2, 3), "R9 stalled event stable", 32'(ev_id), 32'(mk(12'h1A5, 2, 3)));
    step();
    ev_ready = 1'b1;
    wait_empty("R4 all events delivered");
    look_irq(1'b0, "R7 acks drained status");

    // R3: window limits the walk
    do_reset();
    ev_ready = 1'b1;
    regc(2, 12'h111);
    set_en(40, 1'b1);
    raise(40, 8'h08);
    repeat (60) step();
    look_irq(1'b1, "R3 pending outside window keeps irq");
    expect_ev(12'h222, 3, 40, "R3 widened window reaches ch40");
    regc(40, 12'h222);
    wait_empty("R3 widened window delivered");
    look_irq(1'b0, "R3 irq clear after ack");

    // R7: acknowledge details
    do_reset();
    raise(6, 8'h0F);
    set_en(6, 1'b1);
    man_ack(6, 1);
    man_ack(6, 2);
    man_ack(7, 0);
    man_ack(6, 6);
    raise_valid = 1'b1; raise_chan = 8'd6; raise_bits = 8'h20;
    man_chan = 8'd6; man_src = 3'd5; man_cnt++;
    step();
    raise_valid = 1'b0;
    step();
    look_irq(1'b1, "R7 remaining bits keep irq");
    expect_ev(12'h0AB, 0, 6, "R7 bit0 untouched");
    expect_ev(12'h0AB, 3, 6, "R7 bit3 untouched");
    expect_ev(12'h0AB, 5, 6, "R7 raise wins over ack");
    regc(6, 12'h0AB);
    ev_ready = 1'b1;
    wait_empty("R7 remaining bits delivered");

    // R8: masking
    do_reset();
    ev_ready = 1'b1;
    regc(1, 12'h005);
    regc(12, 12'h006);
    raise(1, 8'h02);
    raise(12, 8'h80);
    expect_ev(12'h006, 7, 12, "R8 only enabled channel");
    set_en(12, 1'b1);
    wait_empty("R8 enabled channel delivered");
    look_irq(1'b0, "R8 masked pending ignored");
    set_en(12, 1'b0);
    set_en(12, 1'b0);
    expect_ev(12'h005, 1, 1, "R8 unmask repeated");
    set_en(1, 1'b1);
    set_en(1, 1'b1);
    wait_empty("R8 unmasked channel delivered");

    // R10: unacknowledged source repeats once per walk
    do_reset();
    ev_ready = 1'b1;
    ack_mode = 2;
    regc(20, 12'h003);
    set_en(20, 1'b1);
    expect_ev(12'h003, 2, 20, "R10 first walk");
    expect_ev(12'h003, 2, 20, "R10 second walk");
    expect_ev(12'h003, 2, 20, "R10 third walk");
    raise(20, 8'h04);
    wait_empty("R10 repeated delivery");
    look_irq(1'b0, "R10 stops after ack");

    main_done = 1;
    $display("%0d/%0d checks passed", (n_chk + m_chk) - (n_fail + m_fail), n_chk + m_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!main_done) begin
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("%0d/%0d checks passed", (n_chk + m_chk) - (n_fail + m_fail), n_chk + m_chk + 1);
      $finish;
    end
  end
endmodule